// File: doc/BRIEF.md
# Delay-Programmable TDM Serial Stream Receiver

This block receives several time-division-multiplexed serial input streams that share one 8 kHz frame reference. Every stream runs at its own line rate, from 2.048 to 16.384 Mbit/s. The block runs on an internal clock that is 16 times the 8.192 MHz master clock, and `tickEn` qualifies each cycle as one internal tick. At the highest line rate one bit lasts 8 ticks. A single frame-timing unit finds the frame boundary from the frame pulse and keeps a tick counter of 16384 ticks per frame.

Each stream lane has its own settings:
- a bit-level delay code with quarter-bit resolution;
- a sampling-mode interpretation of that code, chosen by one shared bit;
- a channel offset that moves where channel 0 sits in the frame.

A lane turns each channel's eight bits into a byte. It reports the byte together with a channel index that already has the offset removed, and raises a one-cycle valid strobe with them.

Top module: `tdm_rx_delay`

## Requirements
- R1: During reset and after reset, every `rxValid` bit is low and `rxByte`/`rxChan` read zero. No byte is reported until a frame pulse has been seen.
- R2: The frame boundary (tick 0) comes h ticks after the first tick on which `framePulse` is high. h is 8 when `wideFrame`=0, for a pulse 16 ticks wide (about 122 ns). h is 16 when `wideFrame`=1, for a pulse 32 ticks wide (about 244 ns). Otherwise the tick counter counts 0 to 16383 and wraps.
- R3: Each stream's 2-bit rate code selects the line rate. Codes 0, 1, 2 and 3 select 2.048, 4.096, 8.192 and 16.384 Mbit/s. These have bit periods of 64, 32, 16 and 8 ticks and 32, 64, 128 and 256 channels per frame.
- R4: A byte that occupies raw channel slot r is reported with index (r − chanDelay) mod channels-per-frame. chanDelay is 9 bits wide, so values up to 511 wrap.
- R5: With `sampleMode`=0, the 5-bit delay code d delays the stream by d quarter-bits (code 0 is zero delay, code 3 is 3/4 bit). Each bit is sampled 3/4 of the way through its period.
- R6: With `sampleMode`=1, code bits [4:2] give a delay in whole bits. Code bits [1:0] = k select the sampling point at (k+1)/4 of the bit period, so k=2 is the 3/4 point.
- R7: Bits are shifted in most-significant first. `rxValid` pulses for exactly one cycle per completed byte, so each channel of a frame is reported once per frame.
- R8: Rate, delay code and channel offset act on each stream independently of the other streams.
- R9: The tick counter and the sampling advance only on cycles where `tickEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock (16 x master clock) |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Internal tick qualifier |
| framePulse | input | 1 | 8 kHz frame pulse, active high |
| wideFrame | input | 1 | 1 = wide (32-tick) frame pulse expected |
| sampleMode | input | 1 | Delay-code interpretation, shared by all streams |
| rateSel | input | 2*NUM_STREAMS | Per-stream rate code |
| bitDelay | input | 5*NUM_STREAMS | Per-stream bit delay code |
| chanDelay | input | 9*NUM_STREAMS | Per-stream channel offset |
| serIn | input | NUM_STREAMS | Serial data lines |
| rxByte | output | 8*NUM_STREAMS | Received byte per stream |
| rxChan | output | 8*NUM_STREAMS | Offset-corrected channel index per stream |
| rxValid | output | NUM_STREAMS | One-cycle byte strobe per stream |

## Verification
Four behaviours are checked by the assertions on every cycle:
- the frame counter reloads one cycle after a pulse edge, with the offset that matches the selected pulse width;
- the counter otherwise counts by one, or holds when no tick is present;
- a reported channel index never reaches the channel count of its stream's rate;
- a valid strobe is never longer than one cycle and never appears before frame lock.

Correct byte contents can only be shown by the bench's scenarios. These include MSB-first assembly, the quarter-bit shift and sampling points of both delay-code modes, offset wrap-around beyond the channel count, and independence between streams at mixed rates. The bench drives known patterns through delayed and offset lines and compares every channel of a full frame.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  // ticks per bit at the fastest rate is 2**OS_LOG2, bits per frame at that rate 2**MAXBIT_LOG2
  localparam int OS_LOG2     = 3;
  localparam int MAXBIT_LOG2 = 11;
  localparam int POS_W       = OS_LOG2 + MAXBIT_LOG2;
  localparam int CH_W        = MAXBIT_LOG2 - 3;

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } rate_e;

  // control -> datapath strobes
  typedef struct packed {
    logic sampleEn;
    logic locked;
    pos_t pos;
  } ctrl_t;
endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
#(
  parameter int NARROW_HALF = 8,
  parameter int WIDE_HALF   = 16
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  tickEn,
  input  logic  framePulse,
  input  logic  wideFrame,
  output ctrl_t ctrlBus
);
  logic fpPrev;
  logic locked;
  pos_t pos;
  logic pulseRise;
  pos_t halfTicks;

  assign pulseRise = tickEn && framePulse && !fpPrev;
  assign halfTicks = wideFrame ? pos_t'(WIDE_HALF) : pos_t'(NARROW_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fpPrev <= 1'b0;
      locked <= 1'b0;
      pos    <= '0;
    end else if (tickEn) begin
      fpPrev <= framePulse;
      if (pulseRise) begin
        // boundary lies halfTicks after the first high tick
        pos    <= pos_t'(1) - halfTicks;
        locked <= 1'b1;
      end else begin
        pos <= pos + pos_t'(1);
      end
    end
  end

  assign ctrlBus = '{sampleEn: tickEn, locked: locked, pos: pos};
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrlBus,
  input  logic            sampleMode,
  input  logic [1:0]      rate,
  input  logic [4:0]      bitDelay,
  input  logic [8:0]      chanDelay,
  input  logic            serIn,
  output logic [7:0]      rxByte,
  output logic [CH_W-1:0] rxChan,
  output logic            rxValid
);
  logic [2:0]             bitShift;
  logic [2:0]             quarterShift;
  logic [5:0]             sampleQ;
  pos_t                   delayTicks;
  pos_t                   relTick;
  pos_t                   bitMask;
  logic [MAXBIT_LOG2-1:0] bitIdx;
  logic [CH_W-1:0]        rawCh;
  logic [CH_W-1:0]        chMask;
  logic [CH_W-1:0]        chan;
  logic                   onSample;
  logic                   lastBit;
  logic [6:0]             shReg;

  always_comb begin
    bitShift     = 3'(OS_LOG2 + 3) - {1'b0, rate};
    quarterShift = 3'(OS_LOG2 + 1) - {1'b0, rate};
    // sample point of bit 0, counted in quarter-bits from the frame boundary
    if (!sampleMode) sampleQ = {1'b0, bitDelay} + 6'd3;
    else             sampleQ = {1'b0, bitDelay[4:2], 2'b00} + {4'b0, bitDelay[1:0]} + 6'd1;
    delayTicks = (pos_t'(sampleQ) << quarterShift) - pos_t'(1);
    relTick    = ctrlBus.pos - delayTicks;
    bitMask    = (pos_t'(1) << bitShift) - pos_t'(1);
    onSample   = ctrlBus.sampleEn && ((relTick & bitMask) == '0);
    bitIdx     = MAXBIT_LOG2'(relTick >> bitShift);
    rawCh      = bitIdx[MAXBIT_LOG2-1:3];
    lastBit    = (bitIdx[2:0] == 3'd7);
    chMask     = CH_W'(((CH_W+1)'(1) << (CH_W - 3)) << rate) - CH_W'(1);
    chan       = CH_W'({1'b0, rawCh} - chanDelay) & chMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      rxByte  <= '0;
      rxChan  <= '0;
      rxValid <= 1'b0;
    end else if (onSample) begin
      shReg   <= {shReg[5:0], serIn};
      rxValid <= lastBit && ctrlBus.locked;
      if (lastBit) begin
        rxByte <= {shReg, serIn};
        rxChan <= chan;
      end
    end else begin
      rxValid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_rx_delay.sv
module tdm_rx_delay
  import tdm_rx_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NARROW_HALF = 8,
  parameter int WIDE_HALF   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      framePulse,
  input  logic                      wideFrame,
  input  logic                      sampleMode,
  input  logic [2*NUM_STREAMS-1:0]  rateSel,
  input  logic [5*NUM_STREAMS-1:0]  bitDelay,
  input  logic [9*NUM_STREAMS-1:0]  chanDelay,
  input  logic [NUM_STREAMS-1:0]    serIn,
  output logic [8*NUM_STREAMS-1:0]  rxByte,
  output logic [8*NUM_STREAMS-1:0]  rxChan,
  output logic [NUM_STREAMS-1:0]    rxValid
);
  ctrl_t ctrlBus;

  tdm_rx_ctrl #(.NARROW_HALF(NARROW_HALF), .WIDE_HALF(WIDE_HALF)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .framePulse(framePulse),
    .wideFrame(wideFrame), .ctrlBus(ctrlBus)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    tdm_rx_lane lane_i (
      .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .sampleMode(sampleMode),
      .rate(rateSel[2*s +: 2]), .bitDelay(bitDelay[5*s +: 5]),
      .chanDelay(chanDelay[9*s +: 9]), .serIn(serIn[s]),
      .rxByte(rxByte[8*s +: 8]), .rxChan(rxChan[8*s +: 8]),
      .rxValid(rxValid[s])
    );
  end
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk
  import tdm_rx_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NARROW_HALF = 8,
  parameter int WIDE_HALF   = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     tickEn,
  input logic                     framePulse,
  input logic                     wideFrame,
  input logic [2*NUM_STREAMS-1:0] rateSel,
  input ctrl_t                    ctrlBus,
  input logic [8*NUM_STREAMS-1:0] rxChan,
  input logic [NUM_STREAMS-1:0]   rxValid
);
  logic                     seenHigh;
  logic [2*NUM_STREAMS-1:0] rateQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenHigh <= 1'b0;
      rateQ    <= '0;
    end else begin
      if (tickEn) seenHigh <= framePulse;
      rateQ <= rateSel;
    end
  end

  // R2: pulse edge reloads the counter with the width-dependent offset
  p_realign_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && framePulse && !seenHigh) |=>
      (ctrlBus.pos == ($past(wideFrame) ? pos_t'(1) - pos_t'(WIDE_HALF)
                                        : pos_t'(1) - pos_t'(NARROW_HALF))));

  // R2: otherwise the counter steps by one per tick
  p_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !(framePulse && !seenHigh)) |=>
      (ctrlBus.pos == pos_t'($past(ctrlBus.pos) + pos_t'(1))));

  // R9: without a tick nothing advances
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(ctrlBus.pos));

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_s
    logic [7:0] chTop;
    assign chTop = 8'((9'd32 << rateQ[2*s +: 2]) - 9'd1);

    // R4: index stays inside the channel count of the rate
    p_chan_range_r4: assert property (@(posedge clk) disable iff (!rstN)
      rxValid[s] |-> (rxChan[8*s +: 8] <= chTop));

    // R7: strobe lasts one cycle
    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
      rxValid[s] |=> !rxValid[s]);

    // R1: no byte before frame lock
    p_locked_r1: assert property (@(posedge clk) disable iff (!rstN)
      rxValid[s] |-> ctrlBus.locked);
  end
endmodule

bind tdm_rx_delay tdm_rx_chk #(
  .NUM_STREAMS(NUM_STREAMS), .NARROW_HALF(NARROW_HALF), .WIDE_HALF(WIDE_HALF)
) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .framePulse(framePulse),
  .wideFrame(wideFrame), .rateSel(rateSel), .ctrlBus(ctrlBus),
  .rxChan(rxChan), .rxValid(rxValid)
);

// File: tb/tdm_rx_delay_tb_top.sv
`timescale 1ns/1ps
module tdm_rx_delay_tb_top;
  localparam int NS = 4;
  localparam int F  = 16384;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic framePulse = 1'b0;
  logic wideFrame = 1'b0;
  logic sampleMode = 1'b0;
  logic [2*NS-1:0] rateSel;
  logic [5*NS-1:0] bitDelay;
  logic [9*NS-1:0] chanDelay;
  logic [NS-1:0]   serIn = '0;
  logic [8*NS-1:0] rxByte;
  logic [8*NS-1:0] rxChan;
  logic [NS-1:0]   rxValid;

  int cfgRate [NS];
  int cfgBd   [NS];
  int cfgCd   [NS];
  int seed = 0;
  int bt = 100;
  int cyc = 0;
  logic stallMode = 1'b0;
  int tests = 0;
  int fails = 0;
  logic collecting = 1'b0;
  logic [8:0] got [NS][256];
  int vcount [NS];
  logic done = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int s = 0; s < NS; s++) begin
      rateSel[2*s +: 2]   = 2'(cfgRate[s]);
      bitDelay[5*s +: 5]  = 5'(cfgBd[s]);
      chanDelay[9*s +: 9] = 9'(cfgCd[s]);
    end

  tdm_rx_delay dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .framePulse(framePulse),
    .wideFrame(wideFrame), .sampleMode(sampleMode), .rateSel(rateSel),
    .bitDelay(bitDelay), .chanDelay(chanDelay), .serIn(serIn),
    .rxByte(rxByte), .rxChan(rxChan), .rxValid(rxValid)
  );

  function automatic logic [7:0] pat(int s, int c);
    return 8'(c * 7 + s * 53 + seed);
  endfunction

  // line model built from the requirements: frame bits shifted by the programmed delay
  task automatic drive_lines();
    int h = wideFrame ? 16 : 8;
    framePulse = (bt >= F - h) || (bt < h);
    for (int s = 0; s < NS; s++) begin
      int tpb = 8 << (3 - cfgRate[s]);
      int nch = 32 << cfgRate[s];
      int d = sampleMode ? (cfgBd[s] >> 2) * tpb : cfgBd[s] * tpb / 4;
      int t = (bt - d + F) % F;
      int b = t / tpb;
      int c = ((b / 8) - cfgCd[s] % nch + nch) % nch;
      logic [7:0] v = pat(s, c);
      serIn[s] = v[7 - b % 8];
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (tickEn) bt = (bt + 1) % F;
    tickEn = !(stallMode && (cyc % 8 == 7));
    drive_lines();
  end

  always @(negedge clk)
    if (collecting)
      for (int s = 0; s < NS; s++)
        if (rxValid[s]) begin
          got[s][rxChan[8*s +: 8]] = {1'b0, rxByte[8*s +: 8]};
          vcount[s]++;
        end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (bt == 0);
    while (bt != 0) @(negedge clk);
  endtask

  task automatic measure(string req);
    for (int s = 0; s < NS; s++) begin
      vcount[s] = 0;
      for (int c = 0; c < 256; c++) got[s][c] = 9'h100;
    end
    wait_frame();
    collecting = 1'b1;
    wait_frame();
    collecting = 1'b0;
    for (int s = 0; s < NS; s++) begin
      int nch = 32 << cfgRate[s];
      int bad = 0, firstC = -1, firstA = 0, firstE = 0;
      check(vcount[s] == nch, {"R7 strobe count ", req}, vcount[s], nch);
      for (int c = 0; c < nch; c++)
        if (got[s][c] !== {1'b0, pat(s, c)}) begin
          bad++;
          if (firstC < 0) begin firstC = c; firstA = int'(got[s][c]); firstE = int'(pat(s, c)); end
        end
      check(bad == 0, $sformatf("%s stream %0d chan %0d", req, s, firstC), firstA, firstE);
    end
  endtask

  task automatic set_cfg(int r0, int r1, int r2, int r3, int b0, int b1, int b2, int b3,
                         int c0, int c1, int c2, int c3);
    cfgRate = '{r0, r1, r2, r3};
    cfgBd   = '{b0, b1, b2, b3};
    cfgCd   = '{c0, c1, c2, c3};
  endtask

  task automatic t_reset();
    check(rxValid == '0 && rxByte == '0, "R1 in reset", int'(rxValid), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(rxByte == '0 && rxChan == '0, "R1 after reset", int'(rxByte[7:0]), 0);
    begin
      int v = 0;
      repeat (1000) begin @(negedge clk); if (rxValid != '0) v++; end
      check(v == 0, "R1 no byte before pulse", v, 0);
    end
    wait_frame();
  endtask

  task automatic t_basic();
    seed = 11; sampleMode = 0; wideFrame = 0;
    set_cfg(3, 3, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    measure("R3 R5 basic");
  endtask

  task automatic t_mixed();
    seed = 90;
    set_cfg(0, 1, 2, 3, 0, 3, 7, 17, 0, 5, 1, 100);
    measure("R8 R3 R5 mixed");
  endtask

  task automatic t_chan_wrap();
    seed = 201;
    set_cfg(3, 2, 1, 0, 31, 1, 2, 30, 300, 511, 40, 33);
    measure("R4 R5 wrap");
  endtask

  task automatic t_mode1_wide();
    seed = 47; sampleMode = 1; wideFrame = 1; stallMode = 1;
    set_cfg(3, 3, 2, 1, 5'b00000, 5'b01011, 5'b11101, 5'b00110, 7, 0, 129, 63);
    measure("R6 R2 R9 mode1 wide");
    stallMode = 0;
  endtask

  initial begin
    set_cfg(3, 3, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_mixed();
    t_chan_wrap();
    t_mode1_wide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule